// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Device

This block models the device end of a small serial memory reached over three wires: a select line, a serial clock and a serial data input, plus a serial data output that can float. A host raises select, clocks in a start bit, a two-bit opcode and an address (and, for a write, a data word), then either reads a word back on the output or drops select to launch a self-timed program operation. A synthesizable register array holds the words; all pins are brought into the system clock domain and sampled there.

The program operation runs from an internal counter once select falls and needs no further serial clocking. A write first sets the whole word to ones and then stores the new value, so no prior erase is ever required. While the operation runs, re-selecting the device makes the output show a low level for busy, which turns high once the counter expires. Write and erase only act after a write-enable command; the device starts out write-disabled.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the output is not driven (`do_oe` low) and the device is write-disabled.
- R2: A frame begins with the first 1 seen on `di` at a rising serial clock (earlier 0 bits are skipped), followed by a 2-bit opcode (10 read, 01 write, 11 erase, 00 enable/disable group) and ADDR_W address bits, most significant first.
- R3: For a read, the output is driven from the rising clock that takes the last address bit: first a 0 dummy bit, then the DATA_W bits of the word most significant first, one per following rising clock; the next rising clock releases the output.
- R4: A write frame (address then DATA_W data bits, most significant first) followed by select going low leaves the word at that address equal to the data, whatever it held before.
- R5: An erase frame followed by select going low leaves the addressed word all ones.
- R6: In the enable/disable group, first two address bits 11 enable writing and 00 disable it; write and erase while disabled change no word and start no busy period.
- R7: The program operation lasts PROG_CYCLES system clocks with no serial clock needed; while it runs and select is high, the output is driven low.
- R8: When the operation ends while select is high, the output turns high (ready) and stays driven until select falls.
- R9: Serial clocks and frames presented while the device is busy are ignored: they change no word and start no new operation.
- R10: The output is not driven while select is low and during command, address and write-data entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Device select, active high |
| sk | input | 1 | Serial clock, sampled for rising edges |
| di | input | 1 | Serial data into the device |
| do_dat | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for `do_dat`; low means high impedance |

## Verification
The end of the self-timed operation can fall in the same system clock as a serial clock edge of a new frame the host is already clocking in while busy. The bench provokes this by re-selecting the device right after launching a write and shifting in a complete second write frame that spans the end of the busy period, then dropping select. It judges the outcome at the ports: the status output flips from low to high within that select period, a fresh select shows the output floating (no second operation), and a read of the second frame's address returns its old value.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    F_IDLE,
    F_OP,
    F_ADDR,
    F_DATA,
    F_READ,
    F_ARMED,
    F_DONE
  } frame_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] OP_CTRL  = 2'b00;

  localparam logic [1:0] CTRL_ON  = 2'b11;
  localparam logic [1:0] CTRL_OFF = 2'b00;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sk_rise,
  input  logic              di_s,
  input  logic              busy,
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              armed,
  output logic              armed_erase,
  output logic              ctl_on,
  output logic              ctl_off,
  output logic              do_oe,
  output logic              do_dat
);
  localparam int MAXW = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CW   = $clog2(MAXW + 1) + 1;
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_W - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);
  localparam logic [CW-1:0] READ_END  = CW'(DATA_W);

  frame_t            state;
  logic [1:0]        op;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] rd_sh;
  logic              status;
  logic [ADDR_W-1:0] addr_nxt;

  assign addr_nxt    = {addr[ADDR_W-2:0], di_s};
  assign armed       = (state == F_ARMED);
  assign armed_erase = (op == OP_ERASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= F_IDLE;
      op      <= '0;
      cnt     <= '0;
      addr    <= '0;
      wdata   <= '0;
      rd_sh   <= '0;
      status  <= 1'b0;
      ctl_on  <= 1'b0;
      ctl_off <= 1'b0;
      do_oe   <= 1'b0;
      do_dat  <= 1'b0;
    end else begin
      ctl_on  <= 1'b0;
      ctl_off <= 1'b0;
      if (!cs_s) begin
        state  <= F_IDLE;
        cnt    <= '0;
        status <= 1'b0;
        do_oe  <= 1'b0;
        do_dat <= 1'b0;
      end else if (busy || status) begin
        status <= 1'b1;
        do_oe  <= 1'b1;
        do_dat <= ~busy;
      end else if (sk_rise) begin
        unique case (state)
          F_IDLE: begin
            if (di_s) begin
              state <= F_OP;
              cnt   <= '0;
            end
          end
          F_OP: begin
            op  <= {op[0], di_s};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(1)) begin
              state <= F_ADDR;
              cnt   <= '0;
            end
          end
          F_ADDR: begin
            addr <= addr_nxt;
            cnt  <= cnt + 1'b1;
            if (cnt == ADDR_LAST) begin
              cnt <= '0;
              unique case (op)
                OP_READ: begin
                  state  <= F_READ;
                  do_oe  <= 1'b1;
                  do_dat <= 1'b0;
                end
                OP_WRITE: state <= F_DATA;
                OP_ERASE: state <= F_ARMED;
                default: begin
                  state <= F_DONE;
                  if (addr_nxt[ADDR_W-1 -: 2] == CTRL_ON)  ctl_on  <= 1'b1;
                  if (addr_nxt[ADDR_W-1 -: 2] == CTRL_OFF) ctl_off <= 1'b1;
                end
              endcase
            end
          end
          F_DATA: begin
            wdata <= {wdata[DATA_W-2:0], di_s};
            cnt   <= cnt + 1'b1;
            if (cnt == DATA_LAST) begin
              state <= F_ARMED;
              cnt   <= '0;
            end
          end
          F_READ: begin
            cnt <= cnt + 1'b1;
            if (cnt == READ_END) begin
              state  <= F_DONE;
              do_oe  <= 1'b0;
              do_dat <= 1'b0;
            end else if (cnt == '0) begin
              do_dat <= mem_q[DATA_W-1];
              rd_sh  <= {mem_q[DATA_W-2:0], 1'b0};
            end else begin
              do_dat <= rd_sh[DATA_W-1];
              rd_sh  <= {rd_sh[DATA_W-2:0], 1'b0};
            end
          end
          F_ARMED: state <= F_DONE;
          default: state <= F_DONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_erase,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);
  localparam int TW = $clog2(PROG_CYCLES) + 1;
  localparam logic [TW-1:0] LAST = TW'(PROG_CYCLES - 1);

  logic [TW-1:0]     tcnt;
  logic              erase_q;
  logic [DATA_W-1:0] data_q;
  logic              clear_now;
  logic              store_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      tcnt    <= '0;
      erase_q <= 1'b0;
      data_q  <= '0;
      waddr   <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      tcnt    <= '0;
      erase_q <= is_erase;
      data_q  <= data_i;
      waddr   <= addr_i;
    end else if (busy) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == LAST) busy <= 1'b0;
    end
  end

  assign clear_now = busy && (tcnt == '0);
  assign store_now = busy && (tcnt == LAST) && !erase_q;
  assign we        = clear_now || store_now;
  assign wdata     = clear_now ? '1 : data_q;
endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_dat,
  output logic do_oe
);
  logic [2:0]        pins_s;
  logic              cs_s, sk_s, di_s;
  logic              cs_q, sk_q;
  logic              sk_rise, cs_fall;
  logic              busy, wen, start;
  logic              armed, armed_erase, ctl_on, ctl_off;
  logic [ADDR_W-1:0] f_addr, p_addr;
  logic [DATA_W-1:0] f_data, p_data, mem_q;
  logic              p_we;

  mw_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i({cs, sk, di}), .pin_o(pins_s)
  );
  assign {cs_s, sk_s, di_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
      wen  <= 1'b0;
    end else begin
      cs_q <= cs_s;
      sk_q <= sk_s;
      if (ctl_on)       wen <= 1'b1;
      else if (ctl_off) wen <= 1'b0;
    end
  end

  assign sk_rise = sk_s & ~sk_q;
  assign cs_fall = cs_q & ~cs_s;
  assign start   = cs_fall & armed & wen & ~busy;

  mw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s),
    .busy(busy), .mem_q(mem_q), .addr(f_addr), .wdata(f_data),
    .armed(armed), .armed_erase(armed_erase), .ctl_on(ctl_on),
    .ctl_off(ctl_off), .do_oe(do_oe), .do_dat(do_dat)
  );

  mw_prog_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .is_erase(armed_erase),
    .addr_i(f_addr), .data_i(f_data), .busy(busy), .we(p_we),
    .waddr(p_addr), .wdata(p_data)
  );

  mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(p_we), .waddr(p_addr), .wdata(p_data),
    .raddr(f_addr), .q(mem_q)
  );
endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic busy,
  input logic wen,
  input logic do_oe,
  input logic do_dat
);
  localparam int KW = $clog2(PROG_CYCLES + 1) + 1;
  logic [KW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= '0;
    else              busy_len <= busy_len + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!do_oe && !wen));

  a_r10_float_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !do_oe);

  a_r7_busy_reads_low: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && do_oe) |-> !do_dat);

  a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wen);

  a_r7_cycle_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == KW'(PROG_CYCLES)));
endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .busy(busy), .wen(wen),
  .do_oe(do_oe), .do_dat(do_dat)
);

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int PC = 40;
  localparam int PH = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_dat, do_oe;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) dut (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di),
    .do_dat(do_dat), .do_oe(do_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel();
    cs = 1'b1; wait_clk(PH);
  endtask

  task automatic desel();
    cs = 1'b0; di = 1'b0; wait_clk(PH);
  endtask

  task automatic bitx(input bit v);
    di = v; sk = 1'b1; wait_clk(PH);
    sk = 1'b0; wait_clk(PH);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a);
    bitx(1'b1);
    for (int i = 1; i >= 0; i--) bitx(op[i]);
    for (int i = AW-1; i >= 0; i--) bitx(a[i]);
  endtask

  task automatic finish_prog();
    sel(); wait_clk(PC + 10); desel();
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit wait_done);
    sel();
    send_cmd(2'b01, a);
    check(do_oe == 1'b0, "R10 entry float", int'(do_oe), 0);
    for (int i = DW-1; i >= 0; i--) bitx(d[i]);
    desel();
    if (wait_done) finish_prog();
  endtask

  task automatic do_erase(input logic [AW-1:0] a);
    sel(); send_cmd(2'b11, a); desel(); finish_prog();
  endtask

  task automatic do_ctrl(input logic [1:0] top);
    logic [AW-1:0] a;
    a = '0;
    a[AW-1 -: 2] = top;
    sel(); send_cmd(2'b00, a); desel();
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    sel();
    send_cmd(2'b10, a);
    check(do_oe && !do_dat, "R3 dummy bit", int'({do_oe, do_dat}), 2);
    for (int i = DW-1; i >= 0; i--) begin
      bitx(1'b0);
      d[i] = do_dat;
    end
    check(do_oe == 1'b1, "R3 driven during data", int'(do_oe), 1);
    bitx(1'b0);
    check(do_oe == 1'b0, "R3 release after word", int'(do_oe), 0);
    desel();
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 5) & ((1 << DW) - 1));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    check(do_oe == 1'b0, "R1 reset float", int'(do_oe), 0);

    // R1 / R6: device starts write-disabled, write is ignored and no busy
    do_write(4'd3, 8'h3C, 1'b0);
    sel();
    check(do_oe == 1'b0, "R6 no busy while disabled", int'(do_oe), 0);
    desel();

    do_ctrl(2'b11);
    // R4 sweep: write every address, then read every address
    for (int a = 0; a < (1 << AW); a++) do_write(AW'(a), pat(a), 1'b1);
    for (int a = 0; a < (1 << AW); a++) begin
      do_read(AW'(a), rd);
      check(rd == pat(a), "R4 write sweep", int'(rd), int'(pat(a)));
    end

    // R2: leading zeros before the start bit are skipped
    sel(); bitx(1'b0); bitx(1'b0); desel();
    sel(); bitx(1'b0); bitx(1'b0);
    send_cmd(2'b10, 4'd9);
    check(do_oe && !do_dat, "R2 leading zeros", int'({do_oe, do_dat}), 2);
    for (int i = DW-1; i >= 0; i--) begin bitx(1'b0); rd[i] = do_dat; end
    check(rd == pat(9), "R2 read after zeros", int'(rd), int'(pat(9)));
    desel();

    // R5: erase makes all ones
    do_erase(4'd5);
    do_read(4'd5, rd);
    check(rd == '1, "R5 erase", int'(rd), 255);
    do_read(4'd6, rd);
    check(rd == pat(6), "R5 neighbour kept", int'(rd), int'(pat(6)));

    // R4: write over a word with zeros and ones mixed (auto clear)
    do_write(4'd5, 8'h00, 1'b1);
    do_write(4'd5, 8'hA5, 1'b1);
    do_read(4'd5, rd);
    check(rd == 8'hA5, "R4 overwrite", int'(rd), 165);

    // R7 / R8: busy low while running, ready high after PROG_CYCLES
    do_write(4'd7, 8'h5A, 1'b0);
    sel();
    check(do_oe && !do_dat, "R7 busy low", int'({do_oe, do_dat}), 2);
    wait_clk(PC/2 - PH);
    check(do_oe && !do_dat, "R7 still busy", int'({do_oe, do_dat}), 2);
    wait_clk(PC);
    check(do_oe && do_dat, "R8 ready high", int'({do_oe, do_dat}), 3);
    desel();
    check(do_oe == 1'b0, "R10 float after deselect", int'(do_oe), 0);
    do_read(4'd7, rd);
    check(rd == 8'h5A, "R7 self-timed store", int'(rd), 90);

    // R9: a frame clocked in while busy, spanning the end of the cycle
    do_write(4'd8, 8'h11, 1'b0);
    sel();
    send_cmd(2'b01, 4'd2);
    for (int i = DW-1; i >= 0; i--) bitx(1'b1);
    check(do_oe && do_dat, "R9 ready at end of frame", int'({do_oe, do_dat}), 3);
    desel();
    sel();
    check(do_oe == 1'b0, "R9 no second cycle", int'(do_oe), 0);
    desel();
    do_read(4'd2, rd);
    check(rd == pat(2), "R9 word kept", int'(rd), int'(pat(2)));
    do_read(4'd8, rd);
    check(rd == 8'h11, "R9 first write done", int'(rd), 17);

    // R6: disable then write and erase are ignored
    do_ctrl(2'b00);
    do_write(4'd10, 8'h00, 1'b0);
    sel();
    check(do_oe == 1'b0, "R6 write disabled no busy", int'(do_oe), 0);
    desel();
    do_erase(4'd11);
    do_read(4'd10, rd);
    check(rd == pat(10), "R6 write ignored", int'(rd), int'(pat(10)));
    do_read(4'd11, rd);
    check(rd == pat(11), "R6 erase ignored", int'(rd), int'(pat(11)));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule